// File: doc/BRIEF.md
# SMBus Block Transfer Buffer Sequencer

This block is the block-data engine of an SMBus host controller. It keeps a 32-entry byte buffer, a transfer index and a byte count. It runs three kinds of block transfer: block write, block read, and I2C-style block read with a register offset. Bus signalling sits outside the block. The block talks to it through a request/acknowledge port that moves one byte, or one stop condition, per handshake.

Software uses the block in one of two styles, chosen by a mode input. In buffered style, software fills the whole buffer through the block-data write strobe before a write, or empties it through the block-data read strobe after a read. In byte-at-a-time style, software moves one byte per byte-done handshake. Writing one to the byte-done clear bit moves the sequence on by one byte. A transfer ends when the index reaches the count, or, for reads, when the last-byte input is set at a handshake.

Top module: `smb_blk_seq`

## Requirements
- R1: After reset, busy, done, byte-done and device-error are all 0, and no bus request is raised.
- R2: In buffered mode, while idle, each block-data write stores its byte at the index and increments the index. When the index has reached 32, the next write stores at entry 0 and the index becomes 1.
- R3: A start of a buffered block write (op 0) with the index different from the count sets device-error, resets the index and makes no bus request. With a match, it sends the count byte and then entries 0 to count-1, sets done and clears busy.
- R4: A block read (op 1) first receives a count byte. A count of 0 or above 32 sets device-error. Otherwise it receives count bytes into the buffer and NACKs the final one. In buffered mode it then shows the count on the count output, sets done and keeps busy. Each block-data read strobe steps to the next byte, and busy clears after the count-th byte.
- R5: Byte-at-a-time block write: start sets busy and byte-done and stores the held block-data byte as entry 0. Each byte-done clear advances the index and stores the newly held byte, and byte-done is set again. The clear that makes the index equal the count sends the count byte and the block, sets done and clears busy.
- R6: Byte-at-a-time block read: after the block is received, the first byte is presented on the read-data output with byte-done set. Each byte-done clear presents the next byte. If last-byte is set at that clear, done is set, busy is cleared and byte-done stays low. Otherwise byte-done is set again.
- R7: An I2C block read (op 2) ignores the mode input. It sends the offset byte, then receives one byte per byte-done handshake. A clear with last-byte set receives the final byte with NACK, issues a stop, sets done and clears busy.
- R8: A start while a transfer is still waiting on software abandons it and resets the index. An I2C block read that is still open is first closed with a stop.
- R9: A start while device-error is set makes no bus request and leaves busy low.
- R10: A bus request holds its op and data stable until acknowledged. An acknowledge with NAK sets device-error, clears busy and ends the transfer. Bus op codes: 0 send byte, 1 receive byte, 2 stop.
- R11: Status clear bits are write-one-to-clear: bit 0 done, bit 1 device-error, bit 2 byte-done. A byte-done clear advances the sequence only while a handshake is pending.
- R12: No bus request is raised while busy is low, and byte-done is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_mode_i | input | 1 | 1 selects buffered style, 0 selects byte-at-a-time |
| start_i | input | 1 | Start pulse for the transfer given by op_i |
| op_i | input | 2 | 0 block write, 1 block read, 2 I2C block read |
| last_byte_i | input | 1 | Marks the next read handshake as the final one |
| ofs_i | input | 8 | Register offset sent by an I2C block read |
| cnt_we_i | input | 1 | Loads the byte count |
| cnt_wdata_i | input | 8 | Byte count value |
| blk_we_i | input | 1 | Block-data write strobe |
| blk_wdata_i | input | 8 | Block-data write byte |
| blk_rd_i | input | 1 | Block-data read strobe (buffered read drain) |
| sts_clr_i | input | 3 | Write-one-to-clear: bit0 done, bit1 error, bit2 byte-done |
| blk_rdata_o | output | 8 | Block-data read byte |
| cnt_o | output | 8 | Current byte count |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer complete |
| byte_done_o | output | 1 | One byte ready for the software handshake |
| dev_err_o | output | 1 | Device error |
| bus_req_o | output | 1 | Bus request, held until acknowledged |
| bus_op_o | output | 2 | Bus operation code |
| bus_wdata_o | output | 8 | Byte to send |
| bus_nack_o | output | 1 | NACK the byte being received |
| bus_ack_i | input | 1 | Bus acknowledge, one cycle |
| bus_rdata_i | input | 8 | Received byte, valid with the acknowledge |
| bus_nak_i | input | 1 | Device did not acknowledge, valid with the acknowledge |

## Verification
Buffered writes use random counts from 1 to 32 with random payloads. A 33-byte fill shows the index wrap, and a short fill checks the count-mismatch error, so index tracking is separated from the send path. Reads are fed random counts plus the illegal counts 0 and 40, and they are drained byte by byte so the stepping and the busy release can be seen. The byte-at-a-time write and read sequences, including a read cut short by the last-byte input, check the handshake-driven index. I2C block reads, a start in the middle of a handshake and a start in the middle of a drain, and an injected NAK check the stop, abandon and error paths. A random acknowledge delay runs through all of these.

// File: rtl/smbb_pkg.sv
`timescale 1ns/1ps
package smbb_pkg;
  typedef enum logic [1:0] {
    BUS_SEND = 2'd0,
    BUS_RECV = 2'd1,
    BUS_STOP = 2'd2
  } bus_op_e;

  typedef enum logic [1:0] {
    OP_BLK_WR = 2'd0,
    OP_BLK_RD = 2'd1,
    OP_I2C_RD = 2'd2
  } xfer_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LAUNCH, S_TX, S_RXCNT, S_RX, S_RDLOAD, S_HS,
    S_DRAIN, S_I2C_OFS, S_I2C_RX, S_I2C_RXL, S_STOP
  } seq_st_e;

  localparam int unsigned CLR_DONE = 0;
  localparam int unsigned CLR_ERR  = 1;
  localparam int unsigned CLR_BYTE = 2;
endpackage

// File: rtl/smbb_buf.sv
`timescale 1ns/1ps
module smbb_buf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/smbb_ctl.sv
`timescale 1ns/1ps
module smbb_ctl
  import smbb_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned IW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_mode,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          last_byte,
  input  logic [DW-1:0] ofs,
  input  logic          cnt_we,
  input  logic [DW-1:0] cnt_wdata,
  input  logic          blk_we,
  input  logic [DW-1:0] blk_wdata,
  input  logic          blk_rd,
  input  logic [2:0]    sts_clr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] blk_rdata,
  output logic [DW-1:0] cnt,
  output logic          busy,
  output logic          done,
  output logic          byte_done,
  output logic          dev_err,
  output logic          bus_req,
  output logic [1:0]    bus_op,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_nack,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_nak
);
  seq_st_e       st_q, st_d;
  logic [1:0]    op_q, op_d;
  logic [IW-1:0] idx_q, idx_d, idx_inc, tx_next;
  logic [DW-1:0] cnt_q, cnt_d, blk_q, blk_d;
  logic          busy_q, busy_d, done_q, done_d, bdone_q, bdone_d;
  logic          err_q, err_d, hdr_q, hdr_d, relaunch_q, relaunch_d;
  logic          mode_q, mode_d;
  logic          on_bus, hs_adv;

  assign idx_inc = idx_q + IW'(1);
  assign tx_next = hdr_q ? '0 : idx_inc;
  assign on_bus  = st_q inside {S_TX, S_RXCNT, S_RX, S_I2C_OFS, S_I2C_RX, S_I2C_RXL, S_STOP};
  assign hs_adv  = sts_clr[CLR_BYTE] && bdone_q && (st_q == S_HS);

  // bus side is decoded from state only
  always_comb begin
    bus_req   = on_bus;
    bus_op    = BUS_RECV;
    bus_wdata = '0;
    if (st_q == S_TX) begin
      bus_op    = BUS_SEND;
      bus_wdata = hdr_q ? cnt_q : mem_rdata;
    end else if (st_q == S_I2C_OFS) begin
      bus_op    = BUS_SEND;
      bus_wdata = ofs;
    end else if (st_q == S_STOP) begin
      bus_op    = BUS_STOP;
    end
    bus_nack = ((st_q == S_RX) && (DW'(idx_inc) == cnt_q)) || (st_q == S_I2C_RXL);
  end

  always_comb begin
    st_d       = st_q;
    op_d       = op_q;
    idx_d      = idx_q;
    cnt_d      = cnt_q;
    blk_d      = blk_q;
    busy_d     = busy_q;
    done_d     = done_q;
    bdone_d    = bdone_q;
    err_d      = err_q;
    hdr_d      = hdr_q;
    relaunch_d = relaunch_q;
    mode_d     = mode_q;
    mem_we     = 1'b0;
    mem_waddr  = idx_q[AW-1:0];
    mem_wdata  = blk_q;
    mem_raddr  = idx_q[AW-1:0];

    if (sts_clr[CLR_DONE]) done_d  = 1'b0;
    if (sts_clr[CLR_ERR])  err_d   = 1'b0;
    if (sts_clr[CLR_BYTE]) bdone_d = 1'b0;

    if (!on_bus) begin
      if (cnt_we) cnt_d = cnt_wdata;
      if (blk_we) begin
        if (buf_mode && st_q == S_IDLE) begin
          mem_we    = 1'b1;
          mem_wdata = blk_wdata;
          if (idx_q >= IW'(DEPTH)) begin
            mem_waddr = '0;
            idx_d     = IW'(1);
          end else begin
            idx_d     = idx_inc;
          end
        end else if (!buf_mode) begin
          blk_d = blk_wdata;
        end
      end
    end

    unique case (st_q)
      S_IDLE: ;
      S_LAUNCH: begin
        mode_d = buf_mode;
        if (err_q) begin
          busy_d = 1'b0;
          st_d   = S_IDLE;
        end else begin
          unique case (op_q)
            OP_BLK_WR: begin
              if (buf_mode) begin
                if (DW'(idx_q) != cnt_q) begin
                  err_d  = 1'b1;
                  busy_d = 1'b0;
                  idx_d  = '0;
                  st_d   = S_IDLE;
                end else begin
                  busy_d = 1'b1;
                  hdr_d  = 1'b1;
                  idx_d  = '0;
                  st_d   = S_TX;
                end
              end else begin
                mem_we    = 1'b1;
                mem_waddr = '0;
                mem_wdata = blk_q;
                idx_d     = '0;
                busy_d    = 1'b1;
                bdone_d   = 1'b1;
                st_d      = S_HS;
              end
            end
            OP_BLK_RD: begin busy_d = 1'b1; idx_d = '0; st_d = S_RXCNT; end
            OP_I2C_RD: begin busy_d = 1'b1; idx_d = '0; st_d = S_I2C_OFS; end
            default:   begin err_d = 1'b1; busy_d = 1'b0; st_d = S_IDLE; end
          endcase
        end
      end
      S_TX: begin
        if (bus_ack) begin
          hdr_d = 1'b0;
          idx_d = tx_next;
          if (DW'(tx_next) == cnt_q) begin
            done_d = 1'b1;
            busy_d = 1'b0;
            idx_d  = '0;
            st_d   = S_IDLE;
          end
        end
      end
      S_RXCNT: begin
        if (bus_ack && (bus_rdata == '0 || bus_rdata > DW'(DEPTH))) begin
          err_d  = 1'b1;
          busy_d = 1'b0;
          st_d   = S_IDLE;
        end else if (bus_ack) begin
          cnt_d = bus_rdata;
          idx_d = '0;
          st_d  = S_RX;
        end
      end
      S_RX: begin
        if (bus_ack) begin
          mem_we    = 1'b1;
          mem_wdata = bus_rdata;
          if (DW'(idx_inc) == cnt_q) begin
            idx_d = '0;
            if (mode_q) begin
              done_d = 1'b1;
              st_d   = S_DRAIN;
            end else begin
              st_d   = S_RDLOAD;
            end
          end else begin
            idx_d = idx_inc;
          end
        end
      end
      S_RDLOAD: begin
        blk_d   = mem_rdata;
        bdone_d = 1'b1;
        st_d    = S_HS;
      end
      S_HS: begin
        if (hs_adv) begin
          unique case (op_q)
            OP_BLK_WR: begin
              if (DW'(idx_inc) == cnt_q) begin
                hdr_d = 1'b1;
                idx_d = '0;
                st_d  = S_TX;
              end else begin
                mem_we    = 1'b1;
                mem_waddr = idx_inc[AW-1:0];
                mem_wdata = blk_q;
                idx_d     = idx_inc;
                bdone_d   = 1'b1;
              end
            end
            OP_BLK_RD: begin
              mem_raddr = idx_inc[AW-1:0];
              blk_d     = mem_rdata;
              if (last_byte) begin
                done_d = 1'b1;
                busy_d = 1'b0;
                idx_d  = '0;
                st_d   = S_IDLE;
              end else begin
                idx_d   = idx_inc;
                bdone_d = 1'b1;
              end
            end
            default: begin
              idx_d = idx_inc;
              st_d  = last_byte ? S_I2C_RXL : S_I2C_RX;
            end
          endcase
        end
      end
      S_DRAIN: begin
        if (blk_rd) begin
          if (DW'(idx_inc) == cnt_q) begin
            busy_d = 1'b0;
            idx_d  = '0;
            st_d   = S_IDLE;
          end else begin
            idx_d = idx_inc;
          end
        end
      end
      S_I2C_OFS: if (bus_ack) st_d = S_I2C_RX;
      S_I2C_RX: begin
        if (bus_ack) begin
          blk_d   = bus_rdata;
          bdone_d = 1'b1;
          st_d    = S_HS;
        end
      end
      S_I2C_RXL: begin
        if (bus_ack) begin
          blk_d = bus_rdata;
          st_d  = S_STOP;
        end
      end
      S_STOP: begin
        if (bus_ack && relaunch_q) begin
          relaunch_d = 1'b0;
          st_d       = S_LAUNCH;
        end else if (bus_ack) begin
          done_d = 1'b1;
          busy_d = 1'b0;
          idx_d  = '0;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase

    // a refused byte ends any exchange except the stop
    if (bus_ack && bus_nak && on_bus && st_q != S_STOP) begin
      mem_we  = 1'b0;
      err_d   = 1'b1;
      busy_d  = 1'b0;
      bdone_d = 1'b0;
      idx_d   = '0;
      st_d    = S_IDLE;
    end

    if (start && !on_bus) begin
      mem_we  = 1'b0;
      op_d    = op;
      bdone_d = 1'b0;
      if (st_q != S_IDLE) idx_d = '0;
      if (st_q == S_HS && op_q == OP_I2C_RD) begin
        relaunch_d = 1'b1;
        st_d       = S_STOP;
      end else begin
        st_d = S_LAUNCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      op_q       <= OP_BLK_WR;
      idx_q      <= '0;
      cnt_q      <= '0;
      blk_q      <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      bdone_q    <= 1'b0;
      err_q      <= 1'b0;
      hdr_q      <= 1'b0;
      relaunch_q <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      op_q       <= op_d;
      idx_q      <= idx_d;
      cnt_q      <= cnt_d;
      blk_q      <= blk_d;
      busy_q     <= busy_d;
      done_q     <= done_d;
      bdone_q    <= bdone_d;
      err_q      <= err_d;
      hdr_q      <= hdr_d;
      relaunch_q <= relaunch_d;
      mode_q     <= mode_d;
    end
  end

  assign blk_rdata = (st_q == S_DRAIN) ? mem_rdata : blk_q;
  assign cnt       = cnt_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign byte_done = bdone_q;
  assign dev_err   = err_q;
endmodule

// File: rtl/smb_blk_seq.sv
`timescale 1ns/1ps
module smb_blk_seq #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_mode_i,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic          last_byte_i,
  input  logic [DW-1:0] ofs_i,
  input  logic          cnt_we_i,
  input  logic [DW-1:0] cnt_wdata_i,
  input  logic          blk_we_i,
  input  logic [DW-1:0] blk_wdata_i,
  input  logic          blk_rd_i,
  input  logic [2:0]    sts_clr_i,
  output logic [DW-1:0] blk_rdata_o,
  output logic [DW-1:0] cnt_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          byte_done_o,
  output logic          dev_err_o,
  output logic          bus_req_o,
  output logic [1:0]    bus_op_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_nack_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_nak_i
);
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  smbb_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  smbb_ctl #(.DEPTH(DEPTH), .DW(DW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_mode  (buf_mode_i),
    .start     (start_i),
    .op        (op_i),
    .last_byte (last_byte_i),
    .ofs       (ofs_i),
    .cnt_we    (cnt_we_i),
    .cnt_wdata (cnt_wdata_i),
    .blk_we    (blk_we_i),
    .blk_wdata (blk_wdata_i),
    .blk_rd    (blk_rd_i),
    .sts_clr   (sts_clr_i),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata),
    .blk_rdata (blk_rdata_o),
    .cnt       (cnt_o),
    .busy      (busy_o),
    .done      (done_o),
    .byte_done (byte_done_o),
    .dev_err   (dev_err_o),
    .bus_req   (bus_req_o),
    .bus_op    (bus_op_o),
    .bus_wdata (bus_wdata_o),
    .bus_nack  (bus_nack_o),
    .bus_ack   (bus_ack_i),
    .bus_rdata (bus_rdata_i),
    .bus_nak   (bus_nak_i)
  );
endmodule

// File: rtl/smb_blk_seq_chk.sv
`timescale 1ns/1ps
module smb_blk_seq_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          byte_done_o,
  input logic          dev_err_o,
  input logic          bus_req_o,
  input logic [1:0]    bus_op_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_nack_o,
  input logic          bus_ack_i
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_op_o) && $stable(bus_wdata_o))); // R10

  AST_NO_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_req_o); // R12

  AST_BYTE_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |-> busy_o); // R12

  AST_ERR_ENDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_err_o) |-> (!busy_o && !bus_req_o)); // R10

  AST_NACK_ON_RECV: assert property (@(posedge clk) disable iff (!rst_n)
    bus_nack_o |-> (bus_req_o && bus_op_o == 2'd1)); // R4
endmodule

bind smb_blk_seq smb_blk_seq_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .byte_done_o (byte_done_o),
  .dev_err_o   (dev_err_o),
  .bus_req_o   (bus_req_o),
  .bus_op_o    (bus_op_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_nack_o  (bus_nack_o),
  .bus_ack_i   (bus_ack_i)
);

// File: tb/smb_blk_seq_bench.sv
`timescale 1ns/1ps
module smb_blk_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic buf_mode_i = 1'b1, start_i = 1'b0, last_byte_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [7:0] ofs_i = 8'h00, cnt_wdata_i = 8'h00, blk_wdata_i = 8'h00;
  logic cnt_we_i = 1'b0, blk_we_i = 1'b0, blk_rd_i = 1'b0;
  logic [2:0] sts_clr_i = 3'b000;
  logic [7:0] blk_rdata_o, cnt_o, bus_wdata_o;
  logic busy_o, done_o, byte_done_o, dev_err_o, bus_req_o, bus_nack_o;
  logic [1:0] bus_op_o;
  logic bus_ack_i, bus_nak_i;
  logic [7:0] bus_rdata_i;

  always #5 clk = ~clk;

  smb_blk_seq u_smb_blk_seq (.*);

  // bus device model with random acknowledge delay
  logic [7:0] tx_log [0:255];
  logic [7:0] rx_mem [0:255];
  int ntx, nrx, nstop, dly, nak_at, rx_wp;
  logic last_nack;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack_i <= 1'b0; bus_nak_i <= 1'b0; bus_rdata_i <= 8'h00;
      ntx <= 0; nrx <= 0; nstop <= 0; dly <= 0; last_nack <= 1'b0;
    end else begin
      bus_ack_i <= 1'b0;
      bus_nak_i <= 1'b0;
      if (bus_req_o && !bus_ack_i) begin
        if (dly != 0) dly <= dly - 1;
        else begin
          bus_ack_i <= 1'b1;
          dly <= int'($urandom_range(0, 2));
          case (bus_op_o)
            2'd0: begin
              tx_log[ntx % 256] <= bus_wdata_o;
              bus_nak_i <= (ntx == nak_at);
              ntx <= ntx + 1;
            end
            2'd1: begin
              bus_rdata_i <= rx_mem[nrx % 256];
              nrx <= nrx + 1;
              last_nack <= bus_nack_o;
            end
            default: nstop <= nstop + 1;
          endcase
        end
      end
    end
  end

  int n_run = 0, n_fail = 0;
  logic [7:0] dat [0:63];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic push(logic [7:0] d); rx_mem[rx_wp % 256] = d; rx_wp++; endtask
  task automatic blk_wr(logic [7:0] d);
    blk_we_i = 1'b1; blk_wdata_i = d; tick(1); blk_we_i = 1'b0;
  endtask
  task automatic set_cnt(logic [7:0] n);
    cnt_we_i = 1'b1; cnt_wdata_i = n; tick(1); cnt_we_i = 1'b0;
  endtask
  task automatic go(logic [1:0] o);
    start_i = 1'b1; op_i = o; tick(1); start_i = 1'b0;
  endtask
  task automatic clr(logic [2:0] m);
    sts_clr_i = m; tick(1); sts_clr_i = 3'b000;
  endtask
  task automatic wait_idle(string req);
    int g = 0;
    tick(2);
    while (busy_o && g < 3000) begin tick(1); g++; end
    if (g >= 3000) check({req, " idle timeout"}, 1, 0);
  endtask
  task automatic wait_bit(string req, bit which);
    int g = 0;
    tick(1);
    while (((which ? done_o : byte_done_o) !== 1'b1) && g < 3000) begin tick(1); g++; end
    if (g >= 3000) check({req, " wait timeout"}, 1, 0);
  endtask

  // expected stream of a block write: count byte, then payload
  function automatic logic [7:0] exp_tx(int pos, int n);
    return (pos == 0) ? 8'(n) : dat[pos-1];
  endfunction

  task automatic buffered_write(int n, string req);
    int base;
    for (int i = 0; i < n; i++) begin dat[i] = 8'($urandom); blk_wr(dat[i]); end
    set_cnt(8'(n));
    base = ntx;
    go(2'd0);
    wait_idle(req);
    check({req, " done"}, done_o, 1);
    check({req, " err"}, dev_err_o, 0);
    check({req, " tx count"}, ntx - base, n + 1);
    for (int i = 0; i <= n; i++) check({req, " tx byte"}, tx_log[(base + i) % 256], exp_tx(i, n));
    check("R12 no req after end", bus_req_o, 0);
    clr(3'b001);
  endtask

  initial begin
    int base, bstop, n;
    void'($urandom(32'h5EED_0042));
    nak_at = -1; rx_wp = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 byte_done", byte_done_o, 0);
    check("R1 err", dev_err_o, 0);
    check("R1 req", bus_req_o, 0);

    // R3 / R2: buffered writes, directed 32 then random
    buffered_write(32, "R3 full");
    for (int k = 0; k < 4; k++) buffered_write(int'($urandom_range(1, 31)), "R3 random");

    // R11: byte-done clear while idle does not advance the index
    dat[0] = 8'hA1; dat[1] = 8'hB2;
    blk_wr(dat[0]); blk_wr(dat[1]);
    clr(3'b100);
    set_cnt(8'd2);
    base = ntx;
    go(2'd0); wait_idle("R11");
    check("R11 idle clear ignored", ntx - base, 3);
    check("R11 done", done_o, 1);
    clr(3'b001);

    // R3 mismatch
    for (int i = 0; i < 3; i++) blk_wr(8'(i + 1));
    set_cnt(8'd5);
    base = ntx;
    go(2'd0); tick(2);
    check("R3 mismatch err", dev_err_o, 1);
    check("R3 mismatch no tx", ntx - base, 0);
    check("R3 mismatch busy", busy_o, 0);
    // R9: start with error pending
    base = nrx;
    go(2'd1); tick(4);
    check("R9 no recv", nrx - base, 0);
    check("R9 busy", busy_o, 0);
    clr(3'b010);
    // index was reset by the mismatch
    buffered_write(2, "R3 after reset");

    // R2 wrap: 33 writes, last lands in entry 0
    for (int i = 0; i < 33; i++) begin dat[i] = 8'($urandom); blk_wr(dat[i]); end
    set_cnt(8'd1);
    base = ntx;
    go(2'd0); wait_idle("R2");
    check("R2 wrap count", ntx - base, 2);
    check("R2 wrap byte", tx_log[(base + 1) % 256], dat[32]);
    clr(3'b001);

    // R4 buffered read
    for (int k = 0; k < 3; k++) begin
      n = (k == 0) ? 32 : int'($urandom_range(1, 12));
      push(8'(n));
      for (int i = 0; i < n; i++) begin dat[i] = 8'($urandom); push(dat[i]); end
      go(2'd1); wait_bit("R4", 1'b1);
      check("R4 count", cnt_o, n);
      check("R4 busy held", busy_o, 1);
      check("R4 last nack", last_nack, 1);
      for (int i = 0; i < n; i++) begin
        check("R4 drain byte", blk_rdata_o, dat[i]);
        blk_rd_i = 1'b1; tick(1); blk_rd_i = 1'b0;
      end
      check("R4 busy released", busy_o, 0);
      clr(3'b001);
    end
    // R4 illegal counts
    push(8'd0);
    go(2'd1); wait_idle("R4 zero");
    check("R4 zero count err", dev_err_o, 1);
    clr(3'b010);
    push(8'd40);
    go(2'd1); wait_idle("R4 big");
    check("R4 big count err", dev_err_o, 1);
    clr(3'b010);

    // R5 byte-at-a-time write
    buf_mode_i = 1'b0;
    n = int'($urandom_range(2, 6));
    for (int i = 0; i < n; i++) dat[i] = 8'($urandom);
    blk_wr(dat[0]); set_cnt(8'(n));
    base = ntx;
    go(2'd0); wait_bit("R5", 1'b0);
    check("R5 busy", busy_o, 1);
    for (int i = 1; i < n; i++) begin
      blk_wr(dat[i]); clr(3'b100);
      check("R5 byte_done again", byte_done_o, 1);
    end
    clr(3'b100);
    wait_idle("R5");
    check("R5 done", done_o, 1);
    check("R5 tx count", ntx - base, n + 1);
    for (int i = 0; i <= n; i++) check("R5 tx byte", tx_log[(base + i) % 256], exp_tx(i, n));
    clr(3'b001);

    // R6 byte-at-a-time read, stopped early by last-byte
    n = 5;
    push(8'(n));
    for (int i = 0; i < n; i++) begin dat[i] = 8'($urandom); push(dat[i]); end
    go(2'd1); wait_bit("R6", 1'b0);
    check("R6 first byte", blk_rdata_o, dat[0]);
    for (int i = 1; i <= 2; i++) begin
      last_byte_i = (i == 2);
      clr(3'b100);
      check("R6 next byte", blk_rdata_o, dat[i]);
      check("R6 byte_done", byte_done_o, (i == 2) ? 0 : 1);
    end
    last_byte_i = 1'b0;
    check("R6 done", done_o, 1);
    check("R6 busy", busy_o, 0);
    clr(3'b001);

    // R7 I2C block read with mode input set (ignored)
    buf_mode_i = 1'b1;
    ofs_i = 8'($urandom);
    n = 4;
    for (int i = 0; i < n; i++) begin dat[i] = 8'($urandom); push(dat[i]); end
    base = ntx; bstop = nstop;
    go(2'd2); wait_bit("R7", 1'b0);
    check("R7 offset sent", tx_log[base % 256], ofs_i);
    check("R7 first byte", blk_rdata_o, dat[0]);
    for (int i = 1; i < n; i++) begin
      last_byte_i = (i == n - 1);
      clr(3'b100);
      if (i < n - 1) begin
        wait_bit("R7", 1'b0);
        check("R7 byte", blk_rdata_o, dat[i]);
      end
    end
    last_byte_i = 1'b0;
    wait_idle("R7");
    check("R7 last byte", blk_rdata_o, dat[n-1]);
    check("R7 nack", last_nack, 1);
    check("R7 stop", nstop - bstop, 1);
    check("R7 done", done_o, 1);
    clr(3'b001);

    // R8 abandon an open I2C read with a new block read
    push(8'h5C);
    bstop = nstop;
    go(2'd2); wait_bit("R8", 1'b0);
    push(8'd1); push(8'h77);
    go(2'd1); wait_bit("R8", 1'b1);
    check("R8 stop issued", nstop - bstop, 1);
    check("R8 new count", cnt_o, 1);
    check("R8 new data", blk_rdata_o, 8'h77);
    blk_rd_i = 1'b1; tick(1); blk_rd_i = 1'b0;
    clr(3'b001);
    // R8 abandon a drain: next read starts at entry 0
    push(8'd4);
    for (int i = 0; i < 4; i++) push(8'(8'h10 + i));
    go(2'd1); wait_bit("R8", 1'b1);
    blk_rd_i = 1'b1; tick(1); blk_rd_i = 1'b0;
    clr(3'b001);
    push(8'd2); push(8'hC1); push(8'hC2);
    go(2'd1); wait_bit("R8", 1'b1);
    check("R8 index reset", blk_rdata_o, 8'hC1);
    for (int i = 0; i < 2; i++) begin blk_rd_i = 1'b1; tick(1); blk_rd_i = 1'b0; end
    check("R8 drain end", busy_o, 0);
    clr(3'b001);

    // R10 NAK on first payload byte
    for (int i = 0; i < 3; i++) blk_wr(8'(i));
    set_cnt(8'd3);
    nak_at = ntx + 1;
    go(2'd0); wait_idle("R10");
    nak_at = -1;
    check("R10 nak err", dev_err_o, 1);
    check("R10 no done", done_o, 0);
    check("R10 busy", busy_o, 0);
    clr(3'b010);
    buffered_write(3, "R10 recovered");

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule